// File: doc/BRIEF.md
# Acquisition Configuration Sequencer

This block is the control core of a two-channel capture front end. A host talks to it one byte at a time through a mailbox. Each byte arrives as `cmd_byte` with a one-cycle `cmd_valid` strobe. The block answers by publishing its current state code on `state_code`, which the host reads back to learn where the sequence stands. The top-level states are as follows. Transient start-up (0x00) moves on by itself to idle (0x01). From idle a byte can select trigger-armed (0x21), readout-ready (0x03) or scroll (0x14).

Leaving readout or scroll starts a fixed chain of one-byte parameter states. Each state stores the byte it receives into one configuration register and then moves to the next state. The chain starts with two channel-number states, both published as 0x0F. The channel register changes only when both bytes agree and the value is 1 or 2. The chain continues as follows:

- rate (0x05)
- second step (0x08)
- first step (0x09)
- channel-1 control (0x06)
- channel-2 control (0x07)
- shift (0x0A)
- edge (0x0B)
- position 1 (0x0C)
- position 2 (0x0D)
- trigger level (0x0E)
- offset 1 (0x10)
- gain 1 (0x11)
- offset 2 (0x12)
- gain 2 (0x13)

After gain 2 the block returns to idle.

The four calibration values are first held in internal registers. They are copied to the calibration outputs only while the block sits in idle or scroll, so the outputs stay frozen while the trigger is armed. A trigger event, or a software trigger byte, is remembered while armed. A poll byte then moves the block to readout.

Top module: `acq_cfg_sequencer`

## Requirements
- R1: While `rst_n` is low, `state_code` is 0x00 and every configuration and calibration output is 0x00. On the first rising edge after reset is released, the state becomes idle (0x01).
- R2: In idle (0x01), a strobed byte has the following effect. 0x02 moves to armed (0x21). 0x03 moves to readout (0x03). 0x04 moves to scroll (0x14).
- R3: In armed (0x21), byte 0x99 moves to readout (0x03) if a trigger is pending at that edge. Otherwise the block stays in armed.
- R4: In armed, byte 0xFE marks a trigger as pending and keeps the state, so the next 0x99 reaches readout. Byte 0xFF moves to readout unconditionally. Any pending trigger is cleared on entry to readout. A `trig_event` high at an edge in armed also marks a trigger pending.
- R5: Byte 0x04 in readout, or byte 0xFF in scroll, moves to the first channel-number state (code 0x0F).
- R6: In the first channel-number state, any accepted byte moves the block to the second channel-number state (also 0x0F). In the second state, `cfg_channel` takes the byte only if it equals the first byte and is 1 or 2. Either way the block moves on to rate (0x05).
- R7: Each parameter state stores its accepted byte and advances. The order of states and registers is: 0x05 rate, 0x08 step2, 0x09 step1, 0x06 ctl1, 0x07 ctl2, 0x0A shift, 0x0B edge, 0x0C pos1, 0x0D pos2, 0x0E tlevel, 0x10 offset1, 0x11 gain1, 0x12 offset2, 0x13 gain2. After gain2 the block returns to 0x01.
- R8: The calibration outputs take the stored calibration values at a rising edge only if the state before that edge was idle or scroll. In all other states they hold their value.
- R9: A strobe carrying byte 0x00, or a byte presented without `cmd_valid`, changes neither the state nor any register.
- R10: Any byte other than those listed above, when received in idle, armed, readout or scroll, leaves the state unchanged.
- R11: A `trig_event` outside the armed state is ignored. A poll after a later arm with no new trigger stays in armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Mailbox byte strobe |
| cmd_byte | input | 8 | Mailbox command or parameter byte |
| trig_event | input | 1 | Capture trigger event |
| state_code | output | 8 | Published state code |
| cfg_channel | output | 8 | Selected channel (1 or 2) |
| cfg_rate | output | 8 | Sample-rate index |
| cfg_step2 | output | 8 | Second subset step plus one |
| cfg_step1 | output | 8 | First subset step plus one |
| cfg_ctl1 | output | 8 | Channel-1 range, coupling and trigger source |
| cfg_ctl2 | output | 8 | Channel-2 range, coupling and trigger type |
| cfg_shift | output | 8 | Second subset offset parameter plus one |
| cfg_edge | output | 8 | Trigger edge selection |
| cfg_pos1 | output | 8 | Channel-1 position |
| cfg_pos2 | output | 8 | Channel-2 position |
| cfg_tlevel | output | 8 | Trigger level |
| cal_off1 | output | 8 | Channel-1 offset calibration, gated |
| cal_gain1 | output | 8 | Channel-1 gain calibration, gated |
| cal_off2 | output | 8 | Channel-2 offset calibration, gated |
| cal_gain2 | output | 8 | Channel-2 gain calibration, gated |

## Verification
A strobed byte is taken at one rising edge. The new `state_code` and any configuration register it writes are visible right after that same edge. A calibration output moves one edge later, and only if the block is then in idle or scroll. The trigger-pending flag is also registered: a trigger event or 0xFE at one edge can only satisfy a poll at a later edge. The bench applies each stimulus for exactly one edge and samples on the following falling edge. Its model advances the calibration outputs from the pre-edge state, which reproduces the one-edge lag.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
    localparam int BYTE_W = 8;
    localparam int N_CAL  = 4;

    localparam logic [BYTE_W-1:0] CMD_ARM    = 8'h02;
    localparam logic [BYTE_W-1:0] CMD_READ   = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_CONFIG = 8'h04;
    localparam logic [BYTE_W-1:0] CMD_POLL   = 8'h99;
    localparam logic [BYTE_W-1:0] CMD_FORCE  = 8'hFE;
    localparam logic [BYTE_W-1:0] CMD_ABORT  = 8'hFF;

    typedef enum logic [4:0] {
        S_INIT, S_IDLE, S_ARMED, S_READY, S_SCROLL,
        S_CH_A, S_CH_B, S_RATE, S_STEP2, S_STEP1,
        S_CTL1, S_CTL2, S_SHIFT, S_EDGE, S_POS1,
        S_POS2, S_TLEV, S_OFF1, S_GAIN1, S_OFF2, S_GAIN2
    } seq_state_e;

    function automatic logic [BYTE_W-1:0] code_of(seq_state_e s);
        unique case (s)
            S_INIT:   code_of = 8'h00;
            S_IDLE:   code_of = 8'h01;
            S_ARMED:  code_of = 8'h21;
            S_READY:  code_of = 8'h03;
            S_SCROLL: code_of = 8'h14;
            S_CH_A:   code_of = 8'h0F;
            S_CH_B:   code_of = 8'h0F;
            S_RATE:   code_of = 8'h05;
            S_STEP2:  code_of = 8'h08;
            S_STEP1:  code_of = 8'h09;
            S_CTL1:   code_of = 8'h06;
            S_CTL2:   code_of = 8'h07;
            S_SHIFT:  code_of = 8'h0A;
            S_EDGE:   code_of = 8'h0B;
            S_POS1:   code_of = 8'h0C;
            S_POS2:   code_of = 8'h0D;
            S_TLEV:   code_of = 8'h0E;
            S_OFF1:   code_of = 8'h10;
            S_GAIN1:  code_of = 8'h11;
            S_OFF2:   code_of = 8'h12;
            S_GAIN2:  code_of = 8'h13;
            default:  code_of = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/acq_trig_latch.sv
module acq_trig_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic soft_set,
    input  logic event_in,
    input  logic clear,
    output logic pending
);
    logic pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (clear)
            pending_q <= 1'b0;
        else if (armed && (soft_set || event_in))
            pending_q <= 1'b1;
    end

    assign pending = pending_q;

    // R4: entering readout drops any pending trigger
    a_r4_clear_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !pending_q);
    // R11: a pending trigger only appears while armed
    a_r11_rise_only_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_q) |-> $past(armed));
endmodule

// File: rtl/acq_cal_hold.sv
module acq_cal_hold #(
    parameter int NUM = 4,
    parameter int W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM-1:0]      we,
    input  logic [W-1:0]        wdata,
    input  logic                refresh,
    output logic [NUM-1:0][W-1:0] cal_o
);
    logic [NUM-1:0][W-1:0] stored_q;
    logic [NUM-1:0][W-1:0] out_q;

    for (genvar i = 0; i < NUM; i++) begin : g_cal
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stored_q[i] <= '0;
                out_q[i]    <= '0;
            end else begin
                if (we[i])
                    stored_q[i] <= wdata;
                if (refresh)
                    out_q[i] <= stored_q[i];
            end
        end
    end

    assign cal_o = out_q;

    // R8: outputs frozen outside idle and scroll
    a_r8_cal_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh |=> $stable(out_q));
endmodule

// File: rtl/acq_cfg_sequencer.sv
module acq_cfg_sequencer
    import acq_seq_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [W-1:0] cmd_byte,
    input  logic         trig_event,
    output logic [W-1:0] state_code,
    output logic [W-1:0] cfg_channel,
    output logic [W-1:0] cfg_rate,
    output logic [W-1:0] cfg_step2,
    output logic [W-1:0] cfg_step1,
    output logic [W-1:0] cfg_ctl1,
    output logic [W-1:0] cfg_ctl2,
    output logic [W-1:0] cfg_shift,
    output logic [W-1:0] cfg_edge,
    output logic [W-1:0] cfg_pos1,
    output logic [W-1:0] cfg_pos2,
    output logic [W-1:0] cfg_tlevel,
    output logic [W-1:0] cal_off1,
    output logic [W-1:0] cal_gain1,
    output logic [W-1:0] cal_off2,
    output logic [W-1:0] cal_gain2
);
    seq_state_e state_q, state_d;
    logic       cmd_ok;
    logic       pending;
    logic       enter_ready;
    logic [W-1:0] ch_first_q;
    logic [N_CAL-1:0] cal_we;
    logic [N_CAL-1:0][W-1:0] cal_vec;

    assign cmd_ok = cmd_valid && (cmd_byte != '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_INIT: state_d = S_IDLE;
            S_IDLE: if (cmd_ok) begin
                if (cmd_byte == CMD_ARM)         state_d = S_ARMED;
                else if (cmd_byte == CMD_READ)   state_d = S_READY;
                else if (cmd_byte == CMD_CONFIG) state_d = S_SCROLL;
            end
            S_ARMED: if (cmd_ok) begin
                if (cmd_byte == CMD_ABORT)                state_d = S_READY;
                else if (cmd_byte == CMD_POLL && pending) state_d = S_READY;
            end
            S_READY:  if (cmd_ok && cmd_byte == CMD_CONFIG) state_d = S_CH_A;
            S_SCROLL: if (cmd_ok && cmd_byte == CMD_ABORT)  state_d = S_CH_A;
            S_CH_A:  if (cmd_ok) state_d = S_CH_B;
            S_CH_B:  if (cmd_ok) state_d = S_RATE;
            S_RATE:  if (cmd_ok) state_d = S_STEP2;
            S_STEP2: if (cmd_ok) state_d = S_STEP1;
            S_STEP1: if (cmd_ok) state_d = S_CTL1;
            S_CTL1:  if (cmd_ok) state_d = S_CTL2;
            S_CTL2:  if (cmd_ok) state_d = S_SHIFT;
            S_SHIFT: if (cmd_ok) state_d = S_EDGE;
            S_EDGE:  if (cmd_ok) state_d = S_POS1;
            S_POS1:  if (cmd_ok) state_d = S_POS2;
            S_POS2:  if (cmd_ok) state_d = S_TLEV;
            S_TLEV:  if (cmd_ok) state_d = S_OFF1;
            S_OFF1:  if (cmd_ok) state_d = S_GAIN1;
            S_GAIN1: if (cmd_ok) state_d = S_OFF2;
            S_OFF2:  if (cmd_ok) state_d = S_GAIN2;
            S_GAIN2: if (cmd_ok) state_d = S_IDLE;
            default: state_d = S_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_INIT;
        else        state_q <= state_d;
    end

    // configuration registers (output process)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_first_q  <= '0;
            cfg_channel <= '0;
            cfg_rate    <= '0;
            cfg_step2   <= '0;
            cfg_step1   <= '0;
            cfg_ctl1    <= '0;
            cfg_ctl2    <= '0;
            cfg_shift   <= '0;
            cfg_edge    <= '0;
            cfg_pos1    <= '0;
            cfg_pos2    <= '0;
            cfg_tlevel  <= '0;
        end else if (cmd_ok) begin
            unique case (state_q)
                S_CH_A:  ch_first_q <= cmd_byte;
                S_CH_B:  if (cmd_byte == ch_first_q &&
                             (cmd_byte == W'(1) || cmd_byte == W'(2)))
                             cfg_channel <= cmd_byte;
                S_RATE:  cfg_rate   <= cmd_byte;
                S_STEP2: cfg_step2  <= cmd_byte;
                S_STEP1: cfg_step1  <= cmd_byte;
                S_CTL1:  cfg_ctl1   <= cmd_byte;
                S_CTL2:  cfg_ctl2   <= cmd_byte;
                S_SHIFT: cfg_shift  <= cmd_byte;
                S_EDGE:  cfg_edge   <= cmd_byte;
                S_POS1:  cfg_pos1   <= cmd_byte;
                S_POS2:  cfg_pos2   <= cmd_byte;
                S_TLEV:  cfg_tlevel <= cmd_byte;
                default: ;
            endcase
        end
    end

    assign state_code  = code_of(state_q);
    assign enter_ready = (state_q == S_ARMED) && (state_d == S_READY);

    assign cal_we[0] = cmd_ok && (state_q == S_OFF1);
    assign cal_we[1] = cmd_ok && (state_q == S_GAIN1);
    assign cal_we[2] = cmd_ok && (state_q == S_OFF2);
    assign cal_we[3] = cmd_ok && (state_q == S_GAIN2);

    acq_trig_latch u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (state_q == S_ARMED),
        .soft_set (cmd_ok && cmd_byte == CMD_FORCE),
        .event_in (trig_event),
        .clear    (enter_ready),
        .pending  (pending)
    );

    acq_cal_hold #(.NUM(N_CAL), .W(W)) u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cal_we),
        .wdata   (cmd_byte),
        .refresh (state_q == S_IDLE || state_q == S_SCROLL),
        .cal_o   (cal_vec)
    );

    assign cal_off1  = cal_vec[0];
    assign cal_gain1 = cal_vec[1];
    assign cal_off2  = cal_vec[2];
    assign cal_gain2 = cal_vec[3];

    // R1: start-up state lasts one edge
    a_r1_init_exit: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_INIT |=> state_q == S_IDLE);
    // R9: zero bytes are never taken
    a_r9_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte == '0 && state_q != S_INIT) |=> $stable(state_q));
    // R10: unknown idle byte keeps idle
    a_r10_idle_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && cmd_valid && cmd_byte != CMD_ARM &&
         cmd_byte != CMD_READ && cmd_byte != CMD_CONFIG) |=> state_q == S_IDLE);
    // R6: disagreeing channel bytes keep the channel
    a_r6_mismatch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CH_B && cmd_valid && cmd_byte != ch_first_q) |=> $stable(cfg_channel));
    // R3: a poll without a pending trigger stays armed
    a_r3_poll_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARMED && cmd_valid && cmd_byte == CMD_POLL && !pending) |=> state_q == S_ARMED);
endmodule

// File: tb/acq_cfg_sequencer_tb.sv
module acq_cfg_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       trig_event = 1'b0;
    logic [7:0] state_code, cfg_channel, cfg_rate, cfg_step2, cfg_step1;
    logic [7:0] cfg_ctl1, cfg_ctl2, cfg_shift, cfg_edge, cfg_pos1, cfg_pos2;
    logic [7:0] cfg_tlevel, cal_off1, cal_gain1, cal_off2, cal_gain2;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    acq_cfg_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .trig_event(trig_event), .state_code(state_code),
        .cfg_channel(cfg_channel), .cfg_rate(cfg_rate), .cfg_step2(cfg_step2),
        .cfg_step1(cfg_step1), .cfg_ctl1(cfg_ctl1), .cfg_ctl2(cfg_ctl2),
        .cfg_shift(cfg_shift), .cfg_edge(cfg_edge), .cfg_pos1(cfg_pos1),
        .cfg_pos2(cfg_pos2), .cfg_tlevel(cfg_tlevel), .cal_off1(cal_off1),
        .cal_gain1(cal_gain1), .cal_off2(cal_off2), .cal_gain2(cal_gain2)
    );

    // model state numbering: 0 init,1 idle,2 armed,3 ready,4 scroll,5 chA,6 chB,
    // 7..20 parameter chain in requirement order
    int ms = 0;
    logic [7:0] e_cfg [11];
    logic [7:0] cal_st [4];
    logic [7:0] cal_out [4];
    logic [7:0] e_chan = 0;
    logic [7:0] ch_first = 0;
    bit pend = 0;

    function automatic logic [7:0] code_of(int s);
        logic [7:0] t [21] = '{8'h00, 8'h01, 8'h21, 8'h03, 8'h14, 8'h0F, 8'h0F,
            8'h05, 8'h08, 8'h09, 8'h06, 8'h07, 8'h0A, 8'h0B, 8'h0C, 8'h0D,
            8'h0E, 8'h10, 8'h11, 8'h12, 8'h13};
        return t[s];
    endfunction

    function automatic logic [127:0] actual();
        return {state_code, cfg_channel, cfg_rate, cfg_step2, cfg_step1, cfg_ctl1,
                cfg_ctl2, cfg_shift, cfg_edge, cfg_pos1, cfg_pos2, cfg_tlevel,
                cal_off1, cal_gain1, cal_off2, cal_gain2};
    endfunction

    function automatic logic [127:0] expected();
        return {code_of(ms), e_chan, e_cfg[0], e_cfg[1], e_cfg[2], e_cfg[3],
                e_cfg[4], e_cfg[5], e_cfg[6], e_cfg[7], e_cfg[8], e_cfg[9],
                cal_out[0], cal_out[1], cal_out[2], cal_out[3]};
    endfunction

    task automatic check(string tag);
        checks++;
        if (actual() !== expected()) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, actual(), expected());
        end
    endtask

    task automatic model_reset();
        ms = 0; pend = 0; e_chan = 0; ch_first = 0;
        for (int i = 0; i < 11; i++) e_cfg[i] = 0;
        for (int i = 0; i < 4; i++) begin cal_st[i] = 0; cal_out[i] = 0; end
    endtask

    // one edge of stimulus, model update, then check after the edge
    task automatic tick(bit v, logic [7:0] b, bit t, string tag);
        bit ok = v && (b != 0);
        int nms = ms;
        bit npend = pend;
        if (ms == 1 || ms == 4)
            for (int i = 0; i < 4; i++) cal_out[i] = cal_st[i];
        case (ms)
            0: nms = 1;
            1: if (ok) begin
                   if (b == 8'h02) nms = 2;
                   else if (b == 8'h03) nms = 3;
                   else if (b == 8'h04) nms = 4;
               end
            2: begin
                   if (t || (ok && b == 8'hFE)) npend = 1;
                   if (ok && (b == 8'hFF || (b == 8'h99 && pend))) begin
                       nms = 3; npend = 0;
                   end
               end
            3: if (ok && b == 8'h04) nms = 5;
            4: if (ok && b == 8'hFF) nms = 5;
            5: if (ok) begin ch_first = b; nms = 6; end
            6: if (ok) begin
                   if (b == ch_first && (b == 1 || b == 2)) e_chan = b;
                   nms = 7;
               end
            default: if (ok) begin
                   if (ms <= 16) e_cfg[ms-7] = b;
                   else cal_st[ms-17] = b;
                   nms = (ms == 20) ? 1 : ms + 1;
               end
        endcase
        cmd_valid = v; cmd_byte = b; trig_event = t;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0; cmd_byte = 8'h00; trig_event = 0;
        ms = nms; pend = npend;
        check(tag);
    endtask

    task automatic cmd(logic [7:0] b, string tag);
        tick(1'b1, b, 1'b0, tag);
    endtask

    task automatic run_chain(logic [7:0] c1, logic [7:0] c2, logic [7:0] base);
        cmd(c1, "R6");
        cmd(c2, "R6");
        for (int i = 0; i < 14; i++) cmd(base + 8'(i), "R7");
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1");                      // outputs during reset
        rst_n = 1;
        tick(0, 8'h00, 0, "R1");          // init -> idle
        cmd(8'h55, "R10");
        tick(1, 8'h00, 0, "R9");
        tick(0, 8'h02, 0, "R9");
        cmd(8'h02, "R2");                 // armed
        cmd(8'h99, "R3");                 // no trigger, stays
        cmd(8'h42, "R10");
        cmd(8'hFE, "R4");
        cmd(8'h99, "R4");                 // to readout
        cmd(8'h77, "R10");
        cmd(8'h04, "R5");
        run_chain(8'h02, 8'h02, 8'h20);   // matching channel 2
        tick(0, 8'h00, 0, "R8");          // calibration appears in idle
        tick(0, 8'h00, 1, "R11");         // trigger while idle, ignored
        cmd(8'h02, "R2");
        cmd(8'h99, "R11");                // still armed
        tick(0, 8'h00, 1, "R4");          // real trigger
        cmd(8'h99, "R3");
        cmd(8'h04, "R5");
        run_chain(8'h01, 8'h02, 8'h40);   // mismatch keeps channel
        cmd(8'h04, "R2");                 // scroll
        cmd(8'h12, "R10");
        cmd(8'hFF, "R5");
        run_chain(8'h03, 8'h03, 8'h60);   // equal but out of range
        cmd(8'h02, "R2");
        cmd(8'hFF, "R4");                 // abort to readout
        cmd(8'h04, "R5");
        run_chain(8'h01, 8'h01, 8'h80);
        cmd(8'h03, "R2");
        // random phase, fixed seed
        void'($urandom(32'h5eed1234));
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 9);
            logic [7:0] b;
            case (r)
                0: b = 8'h02; 1: b = 8'h03; 2: b = 8'h04; 3: b = 8'h99;
                4: b = 8'hFE; 5: b = 8'hFF; 6: b = 8'h00;
                7: b = 8'($urandom_range(1, 2));
                default: b = 8'($urandom);
            endcase
            tick($urandom_range(0, 9) < 7, b, $urandom_range(0, 19) == 0, "R8");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule